// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Controller

This block is the receive half of a USB device isochronous OUT endpoint. A serial interface engine upstream hands it one byte per strobe and closes each packet with an end-of-packet pulse. That pulse carries a flag telling whether the packet came in shorter than the maximum packet size. Bytes are staged into a byte FIFO. On end-of-packet the packet is either committed as a whole or thrown away as a whole. A small queue of packet lengths records where each committed packet ends.

Software or a DMA engine drains the FIFO through a byte read port. The read port is show-ahead: the oldest byte is always on the data output, and a pop strobe removes it. A single 8-bit control/status register holds several kinds of field:

- flags that track the packet at the head of the queue;
- a packet-complete flag and an overflow flag, both cleared by writing 1;
- a DMA-enable bit that can be read and written.

An interrupt output is raised while packet-complete is set. When DMA is enabled, it is held off until the FIFO level falls below 32 bytes.

Top module: `iso_out_rx`

## Requirements
- R1: After reset, every bit of the status register reads 0, the interrupt output is 0 and the read data output is 0.
- R2: Committed bytes come out of the read port in arrival order. The oldest byte is presented on the data output, and each cycle with the pop strobe high removes one byte. Status bit 6 reads 1 whenever at least one committed byte is stored.
- R3: A pop while no committed byte is stored returns 0 on the data output and changes no status bit and no stored data.
- R4: Status bit 0 reads 1 while at least one complete packet is queued. Status bit 7 reads 1 while the head packet was flagged short. Both follow the next packet once the last byte of the head packet has been popped.
- R5: Status bit 1 is set in the cycle a packet is committed and is cleared by writing 1 to bit 1. When a commit and such a write fall in the same cycle, the bit stays set.
- R6: A packet that does not fit the free space of the 256-byte FIFO, or that arrives while the length queue (8 entries) is full, is discarded in full. In that case status bit 2 is set, and earlier stored packets are unchanged. Bit 2 is sticky until software writes 1 to it.
- R7: A packet with more than MAX_PKT bytes (default 64) is discarded in full and sets status bit 2.
- R8: Status bit 3 is read/write and enables DMA mode. Bits 4 and 5 always read 0. Writes have no effect on bits 0, 4, 5, 6 and 7.
- R9: The interrupt output is high exactly while status bit 1 is 1 and either bit 3 is 0 or fewer than 32 bytes are stored.
- R10: An end-of-packet with no bytes before it stores nothing and changes no status bit.
- R11: A byte strobe in the same cycle as end-of-packet is taken as the last byte of that packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| rx_eop | input | 1 | End-of-packet pulse |
| rx_short | input | 1 | Packet was short, valid with rx_eop |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register read value |
| rd_pop | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The bench fills the FIFO to exactly 256 bytes and then sends one more byte. A design with an off-by-one in its room check would store the extra byte or corrupt a queued packet. It also overruns the length queue with nine small packets. A controller that checked only byte space would accept the ninth packet and lose its boundary. Further scenarios cover:

- a 65-byte packet, where a missing size limit would leave a truncated packet behind;
- a commit colliding with a write-1 clear, where the wrong priority loses a packet notification;
- the DMA threshold stepped through 32 and 31 bytes, where an inclusive compare would raise the interrupt one byte early;
- a head change from a full packet to a short packet, where flags tied to the newest packet instead of the head would show the short flag too soon.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

  // Status register bit positions (software decodes these)
  localparam int unsigned BIT_SVC    = 0;
  localparam int unsigned BIT_DONE   = 1;
  localparam int unsigned BIT_OVF    = 2;
  localparam int unsigned BIT_DMAEN  = 3;
  localparam int unsigned BIT_NEMPTY = 6;
  localparam int unsigned BIT_SHORT  = 7;

  // Outcome of an end-of-packet event
  typedef enum logic [1:0] {
    EOP_NONE   = 2'd0,
    EOP_COMMIT = 2'd1,
    EOP_DROP   = 2'd2,
    EOP_EMPTY  = 2'd3
  } eop_kind_e;

endpackage

// File: rtl/iso_rx_fifo.sv
// Byte store with a staging write pointer. Bytes of the packet in flight
// are written past the committed pointer and become visible only on commit;
// abort rewinds the staging pointer. DEPTH must be a power of two.
module iso_rx_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  input  logic          abort,
  input  logic          pop_req,
  output logic          pop_ok,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] stage_ptr, stage_ptr_nxt;
  logic [AW-1:0] cmt_ptr, cmt_ptr_nxt;
  logic [AW-1:0] rd_ptr, rd_ptr_nxt;
  logic [CW-1:0] fill_nxt;
  logic [AW-1:0] stage_adv;

  assign pop_ok  = pop_req && (fill != '0);
  assign rd_data = (fill != '0) ? mem[rd_ptr] : '0;

  always_comb begin
    stage_adv     = stage_ptr + AW'(wr_en);
    stage_ptr_nxt = abort ? cmt_ptr : stage_adv;
    cmt_ptr_nxt   = commit ? stage_adv : cmt_ptr;
    rd_ptr_nxt    = rd_ptr + AW'(pop_ok);
    fill_nxt      = fill + (commit ? commit_len : '0) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[stage_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_ptr <= '0;
      cmt_ptr   <= '0;
      rd_ptr    <= '0;
      fill      <= '0;
    end else begin
      stage_ptr <= stage_ptr_nxt;
      cmt_ptr   <= cmt_ptr_nxt;
      rd_ptr    <= rd_ptr_nxt;
      fill      <= fill_nxt;
    end
  end

  // Committed level can never pass the storage size
  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // A pop on an empty store leaves the read side untouched
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fill == '0 && !commit) |=> ($stable(rd_ptr) && fill == '0));

endmodule

// File: rtl/iso_rx_lenq.sv
// Queue of committed packet lengths; tracks how many bytes of the head
// packet have been popped and retires the entry on its last byte.
module iso_rx_lenq #(
  parameter int QDEPTH = 8,
  parameter int LW     = 7,
  localparam int QAW   = $clog2(QDEPTH),
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          push_short,
  input  logic          byte_pop,
  output logic          has_pkt,
  output logic          head_short,
  output logic          full
);

  logic [LW-1:0]  len_q   [QDEPTH];
  logic           short_q [QDEPTH];
  logic [QAW-1:0] wr_ptr, wr_ptr_nxt;
  logic [QAW-1:0] rd_ptr, rd_ptr_nxt;
  logic [QCW-1:0] qcnt, qcnt_nxt;
  logic [LW-1:0]  head_used, head_used_nxt;
  logic           retire;

  assign has_pkt    = (qcnt != '0);
  assign full       = (qcnt == QCW'(QDEPTH));
  assign head_short = has_pkt && short_q[rd_ptr];

  always_comb begin
    retire        = byte_pop && has_pkt && ((head_used + LW'(1)) == len_q[rd_ptr]);
    wr_ptr_nxt    = (wr_ptr == QAW'(QDEPTH - 1)) ? '0 : wr_ptr + QAW'(1);
    rd_ptr_nxt    = (rd_ptr == QAW'(QDEPTH - 1)) ? '0 : rd_ptr + QAW'(1);
    qcnt_nxt      = qcnt + QCW'(push) - QCW'(retire);
    head_used_nxt = head_used;
    if (retire) begin
      head_used_nxt = '0;
    end else if (byte_pop) begin
      head_used_nxt = head_used + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      len_q[wr_ptr]   <= push_len;
      short_q[wr_ptr] <= push_short;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      qcnt      <= '0;
      head_used <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr_nxt;
      if (retire) rd_ptr <= rd_ptr_nxt;
      qcnt      <= qcnt_nxt;
      head_used <= head_used_nxt;
    end
  end

  // Every byte popped from the store belongs to a queued packet
  assert_pop_has_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_pop |-> has_pkt);

  // The assembler never pushes into a full queue
  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/iso_rx_csr.sv
// Status/control register and interrupt qualification.
module iso_rx_csr
  import iso_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       set_done,
  input  logic       set_ovf,
  input  logic       svc,
  input  logic       nempty,
  input  logic       head_short,
  input  logic       fill_low,
  output logic [7:0] rdata,
  output logic       irq
);

  logic done_q, done_nxt;
  logic ovf_q, ovf_nxt;
  logic dma_q, dma_nxt;

  always_comb begin
    done_nxt = done_q;
    if (set_done) begin
      done_nxt = 1'b1;
    end else if (wr && wdata[BIT_DONE]) begin
      done_nxt = 1'b0;
    end
    ovf_nxt = ovf_q;
    if (set_ovf) begin
      ovf_nxt = 1'b1;
    end else if (wr && wdata[BIT_OVF]) begin
      ovf_nxt = 1'b0;
    end
    dma_nxt = wr ? wdata[BIT_DMAEN] : dma_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      done_q <= done_nxt;
      ovf_q  <= ovf_nxt;
      dma_q  <= dma_nxt;
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[BIT_SVC]    = svc;
    rdata[BIT_DONE]   = done_q;
    rdata[BIT_OVF]    = ovf_q;
    rdata[BIT_DMAEN]  = dma_q;
    rdata[BIT_NEMPTY] = nempty;
    rdata[BIT_SHORT]  = head_short;
  end

  assign irq = done_q && (!dma_q || fill_low);

  assert_done_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[BIT_DONE] && !set_done) |=> !done_q);

  assert_done_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> done_q);

  assert_dma_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(dma_q));

endmodule

// File: rtl/iso_out_rx.sv
// Isochronous OUT endpoint receive controller: packet assembly, whole-packet
// drop on overflow, boundary tracking, status register and interrupt.
module iso_out_rx
  import iso_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int MAX_PKT    = 64,
  parameter int LENQ_DEPTH = 8,
  parameter int DMA_LEVEL  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_eop,
  input  logic       rx_short,
  input  logic       csr_wr,
  input  logic [7:0] csr_wdata,
  output logic [7:0] csr_rdata,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       irq_rx
);

  localparam int FCW = $clog2(FIFO_DEPTH) + 1;
  localparam int LW  = $clog2(MAX_PKT + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [LW-1:0]  pkt_len, pkt_len_nxt, end_len;
  logic           pkt_drop, pkt_drop_nxt, end_drop;
  logic           room_ok, byte_ok;
  eop_kind_e      eop_kind;
  logic [FCW-1:0] fill;
  logic           pop_ok;
  logic           lq_full, lq_has, lq_short;
  logic           do_commit, do_drop;

  always_comb begin
    room_ok  = (32'(fill) + 32'(pkt_len)) < 32'(FIFO_DEPTH);
    byte_ok  = rx_vld && !pkt_drop && (32'(pkt_len) < 32'(MAX_PKT)) && room_ok;
    end_len  = pkt_len + LW'(byte_ok);
    end_drop = pkt_drop || (rx_vld && !byte_ok);

    eop_kind = EOP_NONE;
    if (rx_eop) begin
      if (end_drop || lq_full) begin
        eop_kind = (end_len == '0 && !end_drop) ? EOP_EMPTY : EOP_DROP;
      end else if (end_len == '0) begin
        eop_kind = EOP_EMPTY;
      end else begin
        eop_kind = EOP_COMMIT;
      end
    end

    if (rx_eop) begin
      pkt_len_nxt  = '0;
      pkt_drop_nxt = 1'b0;
    end else begin
      pkt_len_nxt  = end_len;
      pkt_drop_nxt = end_drop;
    end
  end

  assign do_commit = (eop_kind == EOP_COMMIT);
  assign do_drop   = (eop_kind == EOP_DROP);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pkt_len  <= '0;
      pkt_drop <= 1'b0;
    end else if (rx_vld || rx_eop) begin
      pkt_len  <= pkt_len_nxt;
      pkt_drop <= pkt_drop_nxt;
    end
  end

  iso_rx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .DW    (8)
  ) u_fifo (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (byte_ok),
    .wr_data    (rx_byte),
    .commit     (do_commit),
    .commit_len (FCW'(end_len)),
    .abort      (do_drop),
    .pop_req    (rd_pop),
    .pop_ok     (pop_ok),
    .rd_data    (rd_data),
    .fill       (fill)
  );

  iso_rx_lenq #(
    .QDEPTH (LENQ_DEPTH),
    .LW     (LW)
  ) u_lenq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push       (do_commit),
    .push_len   (end_len),
    .push_short (rx_short),
    .byte_pop   (pop_ok),
    .has_pkt    (lq_has),
    .head_short (lq_short),
    .full       (lq_full)
  );

  iso_rx_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (csr_wr),
    .wdata      (csr_wdata),
    .set_done   (do_commit),
    .set_ovf    (do_drop),
    .svc        (lq_has),
    .nempty     (fill != '0),
    .head_short (lq_short),
    .fill_low   (32'(fill) < 32'(DMA_LEVEL)),
    .rdata      (csr_rdata),
    .irq        (irq_rx)
  );

  // A discarded packet always leaves the overflow flag set
  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    do_drop |=> csr_rdata[BIT_OVF]);

  // Service flag never claims a packet without stored bytes
  assert_svc_has_data_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    csr_rdata[BIT_SVC] |-> csr_rdata[BIT_NEMPTY]);

  // Empty end-of-packet leaves the committed level alone
  assert_empty_eop_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eop_kind == EOP_EMPTY && !rd_pop) |=> $stable(fill));

  // Oversize packets are never committed
  assert_size_limit_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    do_commit |-> (32'(end_len) <= 32'(MAX_PKT)));

endmodule

// File: tb/sim_iso_out_rx.sv
module sim_iso_out_rx;

  logic       clk;
  logic       rst_n;
  logic       rx_vld;
  logic [7:0] rx_byte;
  logic       rx_eop;
  logic       rx_short;
  logic       csr_wr;
  logic [7:0] csr_wdata;
  logic [7:0] csr_rdata;
  logic       rd_pop;
  logic [7:0] rd_data;
  logic       irq_rx;

  int n_chk;
  int n_fail;

  iso_out_rx u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .rx_eop    (rx_eop),
    .rx_short  (rx_short),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .rd_pop    (rd_pop),
    .rd_data   (rd_data),
    .irq_rx    (irq_rx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic send_pkt(int n, logic [7:0] base, logic sh, logic eop_last);
    for (int i = 0; i < n; i++) begin
      rx_vld  = 1'b1;
      rx_byte = base + 8'(i);
      if (eop_last && i == n - 1) begin
        rx_eop   = 1'b1;
        rx_short = sh;
      end
      @(negedge clk);
    end
    rx_vld = 1'b0;
    rx_eop = 1'b0;
    if (!eop_last || n == 0) begin
      rx_eop   = 1'b1;
      rx_short = sh;
      @(negedge clk);
      rx_eop = 1'b0;
    end
  endtask

  task automatic csr_write(logic [7:0] v);
    csr_wr    = 1'b1;
    csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic pop_bytes(int n, logic [7:0] base, string req);
    for (int i = 0; i < n; i++) begin
      check(req, rd_data, base + 8'(i));
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 status", csr_rdata, 8'h00);
    check("R1 irq", irq_rx, 0);
    check("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_single_short();
    send_pkt(10, 8'h10, 1'b1, 1'b0);
    // svc, done, nempty, short set
    check("R4 R5 status after short pkt", csr_rdata, 8'hC3);
    check("R9 irq with dma off", irq_rx, 1);
    pop_bytes(9, 8'h10, "R2 data order");
    check("R4 svc held mid-packet", csr_rdata[0], 1);
    pop_bytes(1, 8'h19, "R2 data last");
    check("R2 R4 status after drain", csr_rdata, 8'h02);
    csr_write(8'h02);
    check("R5 done cleared", csr_rdata, 8'h00);
    check("R9 irq drops with done", irq_rx, 0);
  endtask

  task automatic t_two_pkts();
    send_pkt(64, 8'h40, 1'b0, 1'b0);
    send_pkt(5, 8'hA0, 1'b1, 1'b0);
    check("R4 head full packet not short", csr_rdata[7], 0);
    pop_bytes(64, 8'h40, "R2 first packet");
    check("R4 short follows new head", csr_rdata[7], 1);
    check("R4 svc still set", csr_rdata[0], 1);
    pop_bytes(5, 8'hA0, "R2 second packet");
    check("R4 flags clear when empty", csr_rdata & 8'hC1, 8'h00);
    csr_write(8'h02);
  endtask

  task automatic t_dma();
    csr_write(8'h08);
    check("R8 dma bit readback", csr_rdata, 8'h08);
    send_pkt(40, 8'h00, 1'b1, 1'b0);
    check("R9 irq held at 40 bytes", irq_rx, 0);
    pop_bytes(8, 8'h00, "R2 dma drain");
    check("R9 irq held at 32 bytes", irq_rx, 0);
    pop_bytes(1, 8'h08, "R2 dma drain");
    check("R9 irq at 31 bytes", irq_rx, 1);
    pop_bytes(31, 8'h09, "R2 dma drain rest");
    csr_write(8'h02);
    check("R8 dma cleared by write", csr_rdata, 8'h00);
  endtask

  task automatic t_overflow();
    for (int p = 0; p < 4; p++) send_pkt(64, 8'(p * 64), 1'b0, 1'b0);
    check("R6 no overflow at exactly full", csr_rdata[2], 0);
    send_pkt(1, 8'hEE, 1'b1, 1'b0);
    check("R6 overflow flag set", csr_rdata[2], 1);
    check("R6 head unchanged", csr_rdata[7], 0);
    for (int p = 0; p < 4; p++) pop_bytes(64, 8'(p * 64), "R6 stored data intact");
    check("R6 dropped byte absent", csr_rdata[6], 0);
    check("R3 empty read gives 0", rd_data, 8'h00);
    csr_write(8'h06);
    check("R6 overflow clears", csr_rdata, 8'h00);
    for (int p = 0; p < 8; p++) send_pkt(2, 8'(8'h80 + p * 2), 1'b0, 1'b0);
    send_pkt(2, 8'hF0, 1'b1, 1'b0);
    check("R6 queue full drop", csr_rdata[2], 1);
    pop_bytes(16, 8'h80, "R6 queued packets intact");
    check("R6 ninth packet absent", csr_rdata[6], 0);
    csr_write(8'h06);
  endtask

  task automatic t_oversize();
    send_pkt(65, 8'h00, 1'b0, 1'b0);
    check("R7 oversize drop flag", csr_rdata[2], 1);
    check("R7 nothing stored", csr_rdata & 8'hC3, 8'h00);
    csr_write(8'h04);
  endtask

  task automatic t_empty_pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    check("R3 status unchanged", csr_rdata, 8'h00);
    check("R3 data 0", rd_data, 8'h00);
    send_pkt(2, 8'h55, 1'b1, 1'b0);
    pop_bytes(2, 8'h55, "R3 later data unaffected");
    csr_write(8'h02);
  endtask

  task automatic t_zero_len();
    send_pkt(0, 8'h00, 1'b1, 1'b0);
    check("R10 zero-length no change", csr_rdata, 8'h00);
    check("R10 no irq", irq_rx, 0);
  endtask

  task automatic t_eop_same_cycle();
    send_pkt(3, 8'h31, 1'b1, 1'b1);
    check("R11 packet committed", csr_rdata, 8'hC3);
    pop_bytes(3, 8'h31, "R11 last byte kept");
    check("R11 exactly 3 bytes", csr_rdata[6], 0);
  endtask

  task automatic t_set_wins();
    // done is still 1 from previous task
    rx_vld = 1'b1; rx_byte = 8'h77; @(negedge clk);
    rx_vld = 1'b0; rx_eop = 1'b1; rx_short = 1'b1;
    csr_wr = 1'b1; csr_wdata = 8'h02;
    @(negedge clk);
    rx_eop = 1'b0; csr_wr = 1'b0;
    check("R5 set wins over clear", csr_rdata[1], 1);
    pop_bytes(1, 8'h77, "R5 data");
    csr_write(8'h02);
    check("R5 plain clear", csr_rdata[1], 0);
  endtask

  task automatic t_ro_bits();
    send_pkt(4, 8'h20, 1'b1, 1'b0);
    csr_write(8'h00);
    check("R8 read-only bits ignore 0 write", csr_rdata, 8'hC3);
    csr_write(8'hF9);
    check("R8 reserved read 0, ro bits kept", csr_rdata, 8'hCB);
    csr_write(8'h00);
    pop_bytes(4, 8'h20, "R8 data intact");
    csr_write(8'h02);
    check("R8 final clear", csr_rdata, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; rx_vld = 1'b0; rx_byte = '0; rx_eop = 1'b0; rx_short = 1'b0;
    csr_wr = 1'b0; csr_wdata = '0; rd_pop = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_short();
    t_two_pkts();
    t_dma();
    t_overflow();
    t_oversize();
    t_empty_pop();
    t_zero_len();
    t_eop_same_cycle();
    t_set_wins();
    t_ro_bits();
    summary();
    $finish;
  end

endmodule